// File: doc/BRIEF.md
# Scanline Table Walker for Register Updates

This block has eight channels. Each channel changes a small group of peripheral registers once per video line by reading a command table from memory. When a frame starts, the enabled channels are armed. On each line strobe the block visits every still-active channel in ascending index order. For each one it fetches a header byte when the previous run has finished, and in indirect mode it also fetches a 16-bit data pointer. It then copies one, two or four bytes from memory to the register bus, using an offset pattern chosen by the channel's mode.

A header byte gives the length of a run in lines and says whether the run rewrites its data on every line or only on the first line. A header whose count is zero retires the channel. Channels aimed at register offset 0x18 retire as soon as they load a header. The live channel set is reported on `active_mask`.

The memory port returns a byte one cycle after a read request. Register-bus writes are single-cycle strobes.

Top module: `hdma_line_engine`

## Requirements
- R1: A `frame_start` pulse aborts any line in progress and sets `active_mask` to `ena_mask`. Each enabled channel gets a run counter of zero, its first-line flag set, and its table pointer loaded from `cfg_start`. That channel's next line therefore begins with a header read.
- R2: `busy` rises only in the cycle after an accepted `line_strobe`, and only if `active_mask` is non-zero. Channels are served in ascending index order. Channels not in `active_mask` cause no traffic. A `line_strobe` arriving while `busy` is high is ignored. When `busy` is low there are no reads and no writes.
- R3: When a channel's run counter is zero, it reads a header at {`cfg_bank`, table pointer}. The header value 0x80 starts a run of 128 lines in which data is written only on the first line.
- R4: For any other header, bits 6:0 give the run length in lines. Bit 7 set means the data is written on every line of the run. Bit 7 clear means it is written only on the first line. Lines without a write only decrement the counter.
- R5: A header whose run length is zero retires the channel. Its bit in `active_mask` clears and it makes no writes.
- R6: In indirect mode (`cfg_indirect`=1), the two table bytes after the header are read low byte first and form the data address. Data is then read from bank `cfg_ibank`. The table pointer advances past those two bytes and is not moved by data reads. In direct mode, data follows the header in the table at `cfg_bank`.
- R7: The write pattern per written line, as register offsets added to `cfg_breg`, depends on the mode. Mode 0 writes +0. Mode 1 writes +0,+1. Modes 2 and 6 write +0,+0. Modes 3 and 7 write +0,+0,+1,+1. Mode 4 writes +0,+1,+2,+3. Mode 5 writes +0,+1,+0,+1. The bytes come from consecutive data addresses.
- R8: After a written line, the data address advances by the number of bytes written, the first-line flag clears and the counter decrements. The next written line continues from the advanced address.
- R9: A channel with `cfg_breg` = 0x18 retires as soon as it loads any header, without writing.
- R10: `mem_rdata` is sampled in the cycle after `mem_rd`. `mem_rd` is never high in two consecutive cycles. Every `bw_valid` cycle directly follows a read cycle.
- R11: After reset, `active_mask` is 0, `busy` is 0, and `mem_rd` and `bw_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame arm pulse |
| line_strobe | input | 1 | Start-of-line pulse |
| ena_mask | input | NCH | Channels to arm at frame start |
| cfg_start | input | NCH x AW | Table start address per channel |
| cfg_bank | input | NCH x BKW | Table bank per channel |
| cfg_ibank | input | NCH x BKW | Indirect data bank per channel |
| cfg_indirect | input | NCH | Indirect addressing select |
| cfg_mode | input | NCH x 3 | Write pattern mode |
| cfg_breg | input | NCH x 8 | Base register offset |
| mem_rdata | input | 8 | Read data, one cycle after request |
| mem_rd | output | 1 | Read request |
| mem_addr | output | BKW+AW | Read address {bank, address} |
| bw_valid | output | 1 | Register write strobe |
| bw_addr | output | 8 | Register offset written |
| bw_data | output | 8 | Byte written |
| active_mask | output | NCH | Channels still live this frame |
| busy | output | 1 | Line processing in progress |

## Verification
On every cycle the assertions check the bus-level rules. Reads never come back to back. Each write follows a read. Nothing happens while idle. Processing starts only from a strobe. The mask gains bits only at frame start. The header decoding, the run lengths, the per-mode offset patterns, indirect pointer assembly, retirement and pointer advance across lines can only be shown by the bench scenarios. In those scenarios a line-by-line reference model predicts every register write and the resulting mask, for directed tables and for random tables and configurations.

// File: rtl/hdma_pkg.sv
package hdma_pkg;
    typedef enum logic [3:0] {
        ST_IDLE, ST_PICK, ST_HDR_A, ST_HDR_D, ST_ILO_A, ST_ILO_D,
        ST_IHI_A, ST_IHI_D, ST_DECIDE, ST_DAT_A, ST_DAT_D
    } hst_e;

    localparam logic [7:0] HDR_LONG     = 8'h80;
    localparam logic [7:0] BREG_BLOCKED = 8'h18;
    localparam logic [7:0] LONG_RUN     = 8'd128;
endpackage

// File: rtl/hdma_pick.sv
module hdma_pick #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/hdma_pattern.sv
module hdma_pattern (
    input  logic [2:0] mode,
    input  logic [1:0] k,
    output logic [1:0] off,
    output logic [2:0] nbytes
);
    always_comb begin
        case (mode)
            3'd0:        begin nbytes = 3'd1; off = 2'd0;          end
            3'd1:        begin nbytes = 3'd2; off = k;             end
            3'd2, 3'd6:  begin nbytes = 3'd2; off = 2'd0;          end
            3'd3, 3'd7:  begin nbytes = 3'd4; off = {1'b0, k[1]};  end
            3'd4:        begin nbytes = 3'd4; off = k;             end
            default:     begin nbytes = 3'd4; off = {1'b0, k[0]};  end
        endcase
    end
endmodule

// File: rtl/hdma_line_engine.sv
module hdma_line_engine
    import hdma_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 16,
    parameter int BKW = 8,
    localparam int CW = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_start,
    input  logic                     line_strobe,
    input  logic [NCH-1:0]           ena_mask,
    input  logic [NCH-1:0][AW-1:0]   cfg_start,
    input  logic [NCH-1:0][BKW-1:0]  cfg_bank,
    input  logic [NCH-1:0][BKW-1:0]  cfg_ibank,
    input  logic [NCH-1:0]           cfg_indirect,
    input  logic [NCH-1:0][2:0]      cfg_mode,
    input  logic [NCH-1:0][7:0]      cfg_breg,
    input  logic [7:0]               mem_rdata,
    output logic                     mem_rd,
    output logic [BKW+AW-1:0]        mem_addr,
    output logic                     bw_valid,
    output logic [7:0]               bw_addr,
    output logic [7:0]               bw_data,
    output logic [NCH-1:0]           active_mask,
    output logic                     busy
);
    typedef struct packed {
        logic [AW-1:0] tbl;
        logic [AW-1:0] dat;
        logic [7:0]    cnt;
        logic          every;
        logic          first;
    } chan_s;

    typedef struct packed {
        hst_e           st;
        logic [CW-1:0]  ch;
        logic [1:0]     k;
        logic [7:0]     lo;
        logic [NCH-1:0] act;
        logic [NCH-1:0] pend;
    } core_s;

    core_s              cq, cd;
    chan_s [NCH-1:0]    chq, chd;
    chan_s              c;

    logic               pick_found;
    logic [CW-1:0]      pick_idx;
    logic [1:0]         pat_off;
    logic [2:0]         pat_n;
    logic [7:0]         hcnt;
    logic               last_k;

    hdma_pick #(.N(NCH)) u_pick (
        .req   (cq.pend),
        .found (pick_found),
        .idx   (pick_idx)
    );

    hdma_pattern u_pat (
        .mode   (cfg_mode[cq.ch]),
        .k      (cq.k),
        .off    (pat_off),
        .nbytes (pat_n)
    );

    assign hcnt   = (mem_rdata == HDR_LONG) ? LONG_RUN : {1'b0, mem_rdata[6:0]};
    assign last_k = ({1'b0, cq.k} == (pat_n - 3'd1));

    always_comb begin
        cd       = cq;
        chd      = chq;
        c        = chq[cq.ch];
        mem_rd   = 1'b0;
        mem_addr = '0;
        bw_valid = 1'b0;
        bw_addr  = '0;
        bw_data  = '0;
        if (frame_start) begin
            cd.st   = ST_IDLE;
            cd.act  = ena_mask;
            cd.pend = '0;
            for (int i = 0; i < NCH; i++) begin
                if (ena_mask[i]) begin
                    chd[i].cnt   = '0;
                    chd[i].first = 1'b1;
                    chd[i].every = 1'b0;
                    chd[i].tbl   = cfg_start[i];
                end
            end
        end else begin
            case (cq.st)
                ST_IDLE: begin
                    if (line_strobe && (|cq.act)) begin
                        cd.pend = cq.act;
                        cd.st   = ST_PICK;
                    end
                end
                ST_PICK: begin
                    if (!pick_found) begin
                        cd.st = ST_IDLE;
                    end else begin
                        cd.ch = pick_idx;
                        cd.st = (chq[pick_idx].cnt == '0) ? ST_HDR_A : ST_DECIDE;
                    end
                end
                ST_HDR_A: begin
                    mem_rd   = 1'b1;
                    mem_addr = {cfg_bank[cq.ch], c.tbl};
                    cd.st    = ST_HDR_D;
                end
                ST_HDR_D: begin
                    c.cnt   = hcnt;
                    c.every = mem_rdata[7] && (mem_rdata != HDR_LONG);
                    if ((hcnt == '0) || (cfg_breg[cq.ch] == BREG_BLOCKED)) begin
                        cd.act[cq.ch]  = 1'b0;
                        cd.pend[cq.ch] = 1'b0;
                        cd.st          = ST_PICK;
                    end else begin
                        c.tbl   = c.tbl + AW'(1);
                        c.dat   = c.tbl;
                        c.first = 1'b1;
                        cd.st   = cfg_indirect[cq.ch] ? ST_ILO_A : ST_DECIDE;
                    end
                end
                ST_ILO_A: begin
                    mem_rd   = 1'b1;
                    mem_addr = {cfg_bank[cq.ch], c.tbl};
                    cd.st    = ST_ILO_D;
                end
                ST_ILO_D: begin
                    cd.lo = mem_rdata;
                    cd.st = ST_IHI_A;
                end
                ST_IHI_A: begin
                    mem_rd   = 1'b1;
                    mem_addr = {cfg_bank[cq.ch], c.tbl + AW'(1)};
                    cd.st    = ST_IHI_D;
                end
                ST_IHI_D: begin
                    c.dat = AW'({mem_rdata, cq.lo});
                    c.tbl = c.tbl + AW'(2);
                    cd.st = ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (!c.every && !c.first) begin
                        c.cnt          = c.cnt - 8'd1;
                        cd.pend[cq.ch] = 1'b0;
                        cd.st          = ST_PICK;
                    end else begin
                        cd.k  = '0;
                        cd.st = ST_DAT_A;
                    end
                end
                ST_DAT_A: begin
                    mem_rd   = 1'b1;
                    mem_addr = {(cfg_indirect[cq.ch] ? cfg_ibank[cq.ch] : cfg_bank[cq.ch]),
                                c.dat + AW'(cq.k)};
                    cd.st    = ST_DAT_D;
                end
                ST_DAT_D: begin
                    bw_valid = 1'b1;
                    bw_addr  = cfg_breg[cq.ch] + {6'd0, pat_off};
                    bw_data  = mem_rdata;
                    if (last_k) begin
                        c.dat = c.dat + AW'(pat_n);
                        if (!cfg_indirect[cq.ch]) c.tbl = c.tbl + AW'(pat_n);
                        c.first        = 1'b0;
                        c.cnt          = c.cnt - 8'd1;
                        cd.pend[cq.ch] = 1'b0;
                        cd.st          = ST_PICK;
                    end else begin
                        cd.k  = cq.k + 2'd1;
                        cd.st = ST_DAT_A;
                    end
                end
                default: cd.st = ST_IDLE;
            endcase
            chd[cq.ch] = c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cq  <= '0;
            chq <= '0;
        end else begin
            cq  <= cd;
            chq <= chd;
        end
    end

    assign active_mask = cq.act;
    assign busy        = (cq.st != ST_IDLE);
endmodule

// File: rtl/hdma_sva.sv
module hdma_sva #(
    parameter int NCH = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           frame_start,
    input logic           line_strobe,
    input logic           mem_rd,
    input logic           bw_valid,
    input logic           busy,
    input logic [NCH-1:0] active_mask
);
    a_r1_mask_grows_only_at_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ((active_mask & ~$past(active_mask)) == '0));

    a_r2_start_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(line_strobe));

    a_r2_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !bw_valid));

    a_r10_no_back_to_back_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    a_r10_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        bw_valid |-> $past(mem_rd));
endmodule

bind hdma_line_engine hdma_sva #(.NCH(NCH)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .line_strobe (line_strobe),
    .mem_rd      (mem_rd),
    .bw_valid    (bw_valid),
    .busy        (busy),
    .active_mask (active_mask)
);

// File: tb/tb_hdma_line_engine.sv
module tb_hdma_line_engine;
    localparam int NCH = 8;
    localparam int AW  = 16;
    localparam int BKW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0;
    logic line_strobe = 1'b0;
    logic [NCH-1:0] ena_mask = '0;
    logic [NCH-1:0][AW-1:0]  cfg_start = '0;
    logic [NCH-1:0][BKW-1:0] cfg_bank = '0;
    logic [NCH-1:0][BKW-1:0] cfg_ibank = '0;
    logic [NCH-1:0]          cfg_indirect = '0;
    logic [NCH-1:0][2:0]     cfg_mode = '0;
    logic [NCH-1:0][7:0]     cfg_breg = '0;
    logic [7:0] mem_rdata = '0;
    logic mem_rd, bw_valid, busy;
    logic [BKW+AW-1:0] mem_addr;
    logic [7:0] bw_addr, bw_data;
    logic [NCH-1:0] active_mask;

    hdma_line_engine #(.NCH(NCH), .AW(AW), .BKW(BKW)) dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_strobe(line_strobe),
        .ena_mask(ena_mask), .cfg_start(cfg_start), .cfg_bank(cfg_bank),
        .cfg_ibank(cfg_ibank), .cfg_indirect(cfg_indirect), .cfg_mode(cfg_mode),
        .cfg_breg(cfg_breg), .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_data(bw_data),
        .active_mask(active_mask), .busy(busy)
    );

    always #4 clk = ~clk;

    logic [7:0] mem [0:4095];
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[{mem_addr[17:16], mem_addr[9:0]}];

    int n_chk = 0, n_fail = 0, cyc = 0, proto_err = 0;
    logic [7:0] got_a [0:63];
    logic [7:0] got_d [0:63];
    int got_n = 0;
    logic prev_rd = 1'b0;

    always @(negedge clk) begin
        if (bw_valid) begin
            if (!prev_rd) proto_err++;
            if (got_n < 64) begin
                got_a[got_n] = bw_addr;
                got_d[got_n] = bw_data;
            end
            got_n++;
        end
        prev_rd = mem_rd;
    end

    // reference state
    logic [15:0] m_tbl [0:7];
    logic [15:0] m_dat [0:7];
    int          m_cnt [0:7];
    bit          m_every [0:7];
    bit          m_first [0:7];
    logic [7:0]  m_act = '0;
    logic [7:0]  e_a [0:63];
    logic [7:0]  e_d [0:63];
    int          e_n = 0;

    function automatic logic [7:0] rdm(input logic [7:0] bk, input logic [15:0] a);
        return mem[{bk[1:0], a[9:0]}];
    endfunction

    function automatic int nb_of(input logic [2:0] m);
        case (m)
            3'd0: return 1;
            3'd1, 3'd2, 3'd6: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic int off_of(input logic [2:0] m, input int k);
        case (m)
            3'd1, 3'd4: return k;
            3'd3, 3'd7: return k / 2;
            3'd5: return k % 2;
            default: return 0;
        endcase
    endfunction

    task automatic model_frame();
        m_act = ena_mask;
        for (int c = 0; c < NCH; c++) begin
            if (ena_mask[c]) begin
                m_cnt[c] = 0; m_first[c] = 1'b1; m_every[c] = 1'b0; m_tbl[c] = cfg_start[c];
            end
        end
    endtask

    task automatic model_line();
        logic [7:0] h;
        logic [7:0] bk;
        int n;
        e_n = 0;
        for (int c = 0; c < NCH; c++) begin
            if (!m_act[c]) continue;
            if (m_cnt[c] == 0) begin
                h = rdm(cfg_bank[c], m_tbl[c]);
                m_cnt[c] = (h == 8'h80) ? 128 : int'(h[6:0]);
                m_every[c] = h[7] && (h != 8'h80);
                if (m_cnt[c] == 0 || cfg_breg[c] == 8'h18) begin
                    m_act[c] = 1'b0;
                    continue;
                end
                m_tbl[c] = m_tbl[c] + 16'd1;
                m_first[c] = 1'b1;
                if (cfg_indirect[c]) begin
                    m_dat[c] = {rdm(cfg_bank[c], m_tbl[c] + 16'd1), rdm(cfg_bank[c], m_tbl[c])};
                    m_tbl[c] = m_tbl[c] + 16'd2;
                end else begin
                    m_dat[c] = m_tbl[c];
                end
            end
            if (!m_every[c] && !m_first[c]) begin
                m_cnt[c]--;
                continue;
            end
            n = nb_of(cfg_mode[c]);
            bk = cfg_indirect[c] ? cfg_ibank[c] : cfg_bank[c];
            for (int k = 0; k < n; k++) begin
                e_a[e_n] = cfg_breg[c] + 8'(off_of(cfg_mode[c], k));
                e_d[e_n] = rdm(bk, m_dat[c] + 16'(k));
                e_n++;
            end
            m_dat[c] = m_dat[c] + 16'(n);
            if (!cfg_indirect[c]) m_tbl[c] = m_tbl[c] + 16'(n);
            m_first[c] = 1'b0;
            m_cnt[c]--;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic do_frame(input logic [7:0] en);
        @(negedge clk);
        ena_mask = en;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        model_frame();
    endtask

    task automatic do_line(input string tag, input bit extra);
        int bad;
        model_line();
        got_n = 0;
        @(negedge clk);
        line_strobe = 1'b1;
        @(negedge clk);
        line_strobe = 1'b0;
        if (extra) begin
            @(negedge clk);
            line_strobe = 1'b1;
            @(negedge clk);
            line_strobe = 1'b0;
        end
        while (busy) @(negedge clk);
        if (got_n != e_n) begin
            chk(1'b0, tag, "write count", got_n, e_n);
        end else begin
            bad = -1;
            for (int i = e_n - 1; i >= 0; i--)
                if (got_a[i] != e_a[i] || got_d[i] != e_d[i]) bad = i;
            if (bad < 0) chk(1'b1, tag, "writes", 0, 0);
            else chk(1'b0, tag, "write addr/data", {got_a[bad], got_d[bad]}, {e_a[bad], e_d[bad]});
        end
        chk(active_mask == m_act, tag, "active_mask", active_mask, m_act);
    endtask

    task automatic setch(input int c, input logic [15:0] st, input logic [7:0] bk,
                         input logic [7:0] ibk, input bit ind, input logic [2:0] md,
                         input logic [7:0] br);
        cfg_start[c] = st; cfg_bank[c] = bk; cfg_ibank[c] = ibk;
        cfg_indirect[c] = ind; cfg_mode[c] = md; cfg_breg[c] = br;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 180000) begin
            n_chk++; n_fail++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 180000);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed1234));
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        repeat (5) @(negedge clk);
        // R11: reset state
        chk(active_mask == '0 && !busy && !mem_rd && !bw_valid, "R11", "reset state",
            {active_mask, busy, mem_rd, bw_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed tables
        mem[12'h000] = 8'h82; mem[12'h001] = 8'hA1; mem[12'h002] = 8'hA2;
        mem[12'h003] = 8'h02; mem[12'h004] = 8'hB1; mem[12'h005] = 8'h00;
        setch(0, 16'h0000, 8'h00, 8'h00, 1'b0, 3'd0, 8'h10);
        mem[12'h040] = 8'h81; mem[12'h041] = 8'h00; mem[12'h042] = 8'h01; mem[12'h043] = 8'h00;
        mem[12'h500] = 8'hC0; mem[12'h501] = 8'hC1; mem[12'h502] = 8'hC2; mem[12'h503] = 8'hC3;
        setch(1, 16'h0040, 8'h00, 8'h01, 1'b1, 3'd4, 8'h20);
        mem[12'h080] = 8'h80; mem[12'h085] = 8'h00;
        setch(2, 16'h0080, 8'h00, 8'h00, 1'b0, 3'd5, 8'h30);
        mem[12'h0C0] = 8'h85;
        setch(3, 16'h00C0, 8'h00, 8'h00, 1'b0, 3'd1, 8'h18);
        mem[12'h100] = 8'h81; mem[12'h105] = 8'h00;
        setch(4, 16'h0100, 8'h00, 8'h00, 1'b0, 3'd3, 8'h40);
        mem[12'h140] = 8'h01; mem[12'h141] = 8'h00; mem[12'h142] = 8'h02; mem[12'h143] = 8'h00;
        setch(5, 16'h0140, 8'h00, 8'h02, 1'b1, 3'd2, 8'h50);
        mem[12'h180] = 8'h03; mem[12'h183] = 8'h00;
        setch(6, 16'h0180, 8'h00, 8'h00, 1'b0, 3'd6, 8'h60);
        mem[12'h1C0] = 8'h82; mem[12'h1C1] = 8'h00; mem[12'h1C2] = 8'h03; mem[12'h1C3] = 8'h00;
        setch(7, 16'h01C0, 8'h00, 8'h03, 1'b1, 3'd7, 8'h70);

        do_frame(8'hFF);
        chk(active_mask == 8'hFF, "R1", "mask after frame", active_mask, 8'hFF);
        do_line("R7", 1'b0);
        chk({got_a[1], got_d[1], got_a[4], got_d[4]} == 32'h20C0_23C3, "R6",
            "indirect data", {got_a[1], got_d[1], got_a[4], got_d[4]}, 32'h20C0_23C3);
        chk(active_mask[3] == 1'b0, "R9", "blocked channel retired", active_mask[3], 0);
        do_line("R8", 1'b0);
        chk(got_n > 0 && got_a[0] == 8'h10 && got_d[0] == 8'hA2, "R8", "second line data",
            {got_a[0], got_d[0]}, 16'h10A2);
        do_line("R2", 1'b1);
        do_line("R4", 1'b0);
        do_line("R5", 1'b0);
        chk(active_mask[0] == 1'b0, "R5", "zero-count header retires", active_mask[0], 0);
        for (int ln = 6; ln <= 128; ln++) do_line("R3", 1'b0);
        chk(active_mask[2] == 1'b1, "R3", "long run still live at line 128", active_mask[2], 1);
        do_line("R3", 1'b0);
        chk(active_mask[2] == 1'b0, "R3", "long run ended at line 129", active_mask[2], 0);

        // re-arm mid-stream
        do_frame(8'h03);
        chk(active_mask == 8'h03, "R1", "mask after re-arm", active_mask, 8'h03);
        do_line("R1", 1'b0);
        do_line("R1", 1'b0);

        // random frames
        for (int f = 0; f < 6; f++) begin
            for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
            for (int c = 0; c < NCH; c++)
                setch(c, 16'($urandom), 8'($urandom), 8'($urandom), 1'($urandom),
                      3'($urandom), ($urandom % 5 == 0) ? 8'h18 : 8'($urandom));
            do_frame(8'($urandom));
            for (int ln = 0; ln < 30; ln++) do_line("R4", 1'b0);
        end

        chk(proto_err == 0, "R10", "write without preceding read", proto_err, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule